// File: doc/BRIEF.md
# Mailbox transmit request cancel tracker

This block holds the per-mailbox transmit status for a CAN controller with a parameterised number of mailboxes (32 by default). Each mailbox has four flags. The pending flag means a transmit has been requested. The cancel flag means the host has asked to withdraw that request. The abort-acknowledge flag reports a withdrawn or failed transmit. The transmit-acknowledge flag reports a frame that went out successfully. The host raises pending and cancel flags with write-one strobes and drops acknowledge flags with write-one strobes.

A protocol engine drives the other side. It signals each internal arbitration round, meaning the step that picks the next pending mailbox. It also reports the index of the mailbox that has started sending, and whether that send ended in success or in failure (lost arbitration or a bus error). At most one mailbox is on the bus at any time. A cancel cannot stop a mailbox that is already sending. Its outcome decides which acknowledge flag is raised.

Top module: `mbx_tx_tracker`

## Requirements
- R1: Under reset, every pending, cancel, abort-acknowledge and transmit-acknowledge bit is 0 and `tx_busy_o` is 0.
- R2: A 1 in bit k of `pend_set_i` sets `pend_o[k]` on the next clock. A 0 in any bit leaves that pending bit unchanged.
- R3: A 1 in bit k of `cancel_set_i` sets `cancel_o[k]` on the next clock for k from 1 up. A 0 leaves the bit unchanged. Mailbox 0 has no cancel flag, so `cancel_o[0]` is always 0.
- R4: On a clock with `arb_evt_i` high, each mailbox that is pending, has its cancel bit set and is not transmitting gets its pending and cancel bits cleared and its abort-acknowledge bit set.
- R5: On a clock with `arb_evt_i` high, a cancel bit on a mailbox that is not pending is cleared. Its pending and acknowledge bits do not change.
- R6: The transmitting mailbox is never aborted by arbitration. This includes the one whose `tx_start_i` comes in the same clock. Its pending and cancel bits stay set.
- R7: `tx_ok_i` while transmitting clears the pending and cancel bits of `tx_idx_o` and sets its transmit-acknowledge bit. This holds even if a cancel was requested.
- R8: `tx_fail_i` while transmitting clears the pending and cancel bits of `tx_idx_o` and sets its abort-acknowledge bit.
- R9: A 1 on `abort_ack_clr_i[k]` or `tx_ack_clr_i[k]` clears that acknowledge bit. If hardware sets the same bit in the same clock, the bit ends up set.
- R10: If a host pending set and a hardware clear of the same bit come in the same clock, the pending bit ends up set.
- R11: `tx_start_i` captures `tx_start_idx_i` into `tx_idx_o` and raises `tx_busy_o`. A success or failure report drops `tx_busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_set_i | input | N_MBX | Host write-one-to-set of pending bits |
| cancel_set_i | input | N_MBX | Host write-one-to-set of cancel bits (bit 0 ignored) |
| abort_ack_clr_i | input | N_MBX | Host write-one-to-clear of abort-acknowledge bits |
| tx_ack_clr_i | input | N_MBX | Host write-one-to-clear of transmit-acknowledge bits |
| arb_evt_i | input | 1 | Internal arbitration round; cancels are serviced |
| tx_start_i | input | 1 | A mailbox has started sending |
| tx_start_idx_i | input | IDX_W | Index of the mailbox that started |
| tx_ok_i | input | 1 | Current transmission finished successfully |
| tx_fail_i | input | 1 | Current transmission failed (arbitration loss or bus error) |
| pend_o | output | N_MBX | Pending bits |
| cancel_o | output | N_MBX | Cancel bits |
| abort_ack_o | output | N_MBX | Abort-acknowledge bits |
| tx_ack_o | output | N_MBX | Transmit-acknowledge bits |
| tx_busy_o | output | 1 | A mailbox is transmitting |
| tx_idx_o | output | IDX_W | Index of the transmitting mailbox |

## Verification
The hardest case to reach is a cancel that meets a mailbox already on the bus. That covers two situations: an arbitration round while the mailbox is sending, and an arbitration round in the same clock as the start report. The stimulus sets up each one with a pending write, a cancel write and then a start. In one case the arbitration pulse comes a clock later. In the other it comes in the same clock as the start. The bench then checks that both flags survive, and that only the later success or failure report decides which acknowledge flag is raised. The bench also collides host clears and sets with hardware events in a single clock to check the priority rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_NUM_DEF = 32;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_state_e;
endpackage

// File: rtl/mbx_tx_slot.sv
module mbx_tx_slot #(
  parameter int unsigned N_MBX = mbx_pkg::MBX_NUM_DEF,
  localparam int unsigned IDX_W = $clog2(N_MBX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             ok_i,
  input  logic             fail_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_MBX-1:0] busy_oh_o,
  output logic [N_MBX-1:0] ok_oh_o,
  output logic [N_MBX-1:0] fail_oh_o
);
  import mbx_pkg::*;

  localparam logic [N_MBX-1:0] ONE = {{(N_MBX-1){1'b0}}, 1'b1};

  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [N_MBX-1:0] cur_oh, start_oh;
  logic             busy, done;

  assign busy     = (state_q == TX_BUSY);
  assign done     = busy & (ok_i | fail_i);
  assign cur_oh   = busy ? (ONE << idx_q) : '0;
  assign start_oh = start_i ? (ONE << start_idx_i) : '0;

  always_comb begin
    state_d = state_q;
    if (start_i)   state_d = TX_BUSY;
    else if (done) state_d = TX_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) idx_q <= start_idx_i;
    end
  end

  // a mailbox starting this cycle is already shielded from cancellation
  assign busy_oh_o = cur_oh | start_oh;
  assign ok_oh_o   = (busy & ok_i)   ? cur_oh : '0;
  assign fail_oh_o = (busy & fail_i) ? cur_oh : '0;
  assign busy_o    = busy;
  assign idx_o     = idx_q;
endmodule

// File: rtl/mbx_status_cell.sv
module mbx_status_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_set_i,
  input  logic cancel_set_i,
  input  logic abak_clr_i,
  input  logic txak_clr_i,
  input  logic arb_i,
  input  logic busy_i,
  input  logic ok_i,
  input  logic fail_i,
  output logic pend_o,
  output logic cancel_o,
  output logic abak_o,
  output logic txak_o
);
  logic pend_q, cancel_q, abak_q, txak_q;
  logic svc, sweep, done;

  assign sweep = arb_i & ~busy_i;
  assign svc   = sweep & pend_q & cancel_q;
  assign done  = ok_i | fail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      cancel_q <= 1'b0;
      abak_q   <= 1'b0;
      txak_q   <= 1'b0;
    end else begin
      // host sets and hardware sets win over the matching clears
      pend_q   <= pend_set_i   | (pend_q   & ~svc   & ~done);
      cancel_q <= cancel_set_i | (cancel_q & ~sweep & ~done);
      abak_q   <= svc | fail_i | (abak_q & ~abak_clr_i);
      txak_q   <= ok_i         | (txak_q   & ~txak_clr_i);
    end
  end

  assign pend_o   = pend_q;
  assign cancel_o = cancel_q;
  assign abak_o   = abak_q;
  assign txak_o   = txak_q;
endmodule

// File: rtl/mbx_tx_tracker.sv
module mbx_tx_tracker #(
  parameter int unsigned N_MBX = mbx_pkg::MBX_NUM_DEF,
  localparam int unsigned IDX_W = $clog2(N_MBX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MBX-1:0] pend_set_i,
  input  logic [N_MBX-1:0] cancel_set_i,
  input  logic [N_MBX-1:0] abort_ack_clr_i,
  input  logic [N_MBX-1:0] tx_ack_clr_i,
  input  logic             arb_evt_i,
  input  logic             tx_start_i,
  input  logic [IDX_W-1:0] tx_start_idx_i,
  input  logic             tx_ok_i,
  input  logic             tx_fail_i,
  output logic [N_MBX-1:0] pend_o,
  output logic [N_MBX-1:0] cancel_o,
  output logic [N_MBX-1:0] abort_ack_o,
  output logic [N_MBX-1:0] tx_ack_o,
  output logic             tx_busy_o,
  output logic [IDX_W-1:0] tx_idx_o
);
  // mailbox 0 carries no cancel flag
  localparam logic [N_MBX-1:0] CANCEL_MASK = {{(N_MBX-1){1'b1}}, 1'b0};

  logic [N_MBX-1:0] busy_oh, ok_oh, fail_oh, cancel_set_m;

  assign cancel_set_m = cancel_set_i & CANCEL_MASK;

  mbx_tx_slot #(.N_MBX(N_MBX)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (tx_start_i),
    .start_idx_i (tx_start_idx_i),
    .ok_i        (tx_ok_i),
    .fail_i      (tx_fail_i),
    .busy_o      (tx_busy_o),
    .idx_o       (tx_idx_o),
    .busy_oh_o   (busy_oh),
    .ok_oh_o     (ok_oh),
    .fail_oh_o   (fail_oh)
  );

  for (genvar k = 0; k < N_MBX; k++) begin : g_mbx
    mbx_status_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pend_set_i   (pend_set_i[k]),
      .cancel_set_i (cancel_set_m[k]),
      .abak_clr_i   (abort_ack_clr_i[k]),
      .txak_clr_i   (tx_ack_clr_i[k]),
      .arb_i        (arb_evt_i),
      .busy_i       (busy_oh[k]),
      .ok_i         (ok_oh[k]),
      .fail_i       (fail_oh[k]),
      .pend_o       (pend_o[k]),
      .cancel_o     (cancel_o[k]),
      .abak_o       (abort_ack_o[k]),
      .txak_o       (tx_ack_o[k])
    );
  end
endmodule

// File: rtl/mbx_tx_tracker_chk.sv
module mbx_tx_tracker_chk #(
  parameter int unsigned N_MBX = 32,
  localparam int unsigned IDX_W = $clog2(N_MBX)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MBX-1:0] cancel_set_i,
  input logic             arb_evt_i,
  input logic             tx_start_i,
  input logic             tx_ok_i,
  input logic             tx_fail_i,
  input logic [N_MBX-1:0] pend_o,
  input logic [N_MBX-1:0] cancel_o,
  input logic [N_MBX-1:0] abort_ack_o,
  input logic [N_MBX-1:0] tx_ack_o,
  input logic             tx_busy_o,
  input logic [IDX_W-1:0] tx_idx_o
);
  AST_NO_CANCEL_MBX0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cancel_o[0]); // R3

  AST_ARB_SWEEPS_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_evt_i && !tx_start_i && !tx_busy_o && cancel_set_i == '0) |=> cancel_o == '0); // R5

  AST_ARB_ABORTS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_evt_i && !tx_start_i && !tx_busy_o)
    |=> (abort_ack_o & $past(pend_o & cancel_o)) == $past(pend_o & cancel_o)); // R4

  AST_BUSY_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && arb_evt_i && !tx_ok_i && !tx_fail_i && pend_o[tx_idx_o])
    |=> pend_o[$past(tx_idx_o)]); // R6

  AST_OK_SETS_TXAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && tx_ok_i) |=> tx_ack_o[$past(tx_idx_o)]); // R7

  AST_FAIL_SETS_ABAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && tx_fail_i && !tx_ok_i) |=> abort_ack_o[$past(tx_idx_o)]); // R8

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && (tx_ok_i || tx_fail_i) && !tx_start_i) |=> !tx_busy_o); // R11
endmodule

bind mbx_tx_tracker mbx_tx_tracker_chk #(.N_MBX(N_MBX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cancel_set_i (cancel_set_i),
  .arb_evt_i    (arb_evt_i),
  .tx_start_i   (tx_start_i),
  .tx_ok_i      (tx_ok_i),
  .tx_fail_i    (tx_fail_i),
  .pend_o       (pend_o),
  .cancel_o     (cancel_o),
  .abort_ack_o  (abort_ack_o),
  .tx_ack_o     (tx_ack_o),
  .tx_busy_o    (tx_busy_o),
  .tx_idx_o     (tx_idx_o)
);

// File: tb/mbx_tx_tracker_tb.sv
module mbx_tx_tracker_tb_top;
  localparam int unsigned N = 32;
  localparam int unsigned IW = 5;

  // op codes: 0 pend set, 1 cancel set, 2 arb, 3 start, 4 ok, 5 fail, 6 abak clr, 7 txak clr
  // vector: {op[2:0], idx[4:0], expected {pend,cancel,abak,txak}}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 5'd5,  4'b1000}, {3'd1, 5'd5,  4'b1100}, {3'd2, 5'd5,  4'b0010},
    {3'd6, 5'd5,  4'b0000}, {3'd1, 5'd7,  4'b0100}, {3'd2, 5'd7,  4'b0000},
    {3'd0, 5'd9,  4'b1000}, {3'd3, 5'd9,  4'b1000}, {3'd1, 5'd9,  4'b1100},
    {3'd2, 5'd9,  4'b1100}, {3'd4, 5'd9,  4'b0001}, {3'd7, 5'd9,  4'b0000},
    {3'd0, 5'd12, 4'b1000}, {3'd3, 5'd12, 4'b1000}, {3'd5, 5'd12, 4'b0010},
    {3'd1, 5'd0,  4'b0000}, {3'd0, 5'd0,  4'b1000}, {3'd6, 5'd12, 4'b0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pend_set, cancel_set, abak_clr, txak_clr;
  logic          arb, start, ok, fail;
  logic [IW-1:0] start_idx;
  logic [N-1:0]  pend_o, cancel_o, abak_o, txak_o;
  logic          busy_o;
  logic [IW-1:0] idx_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  mbx_tx_tracker #(.N_MBX(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend_set_i(pend_set), .cancel_set_i(cancel_set),
    .abort_ack_clr_i(abak_clr), .tx_ack_clr_i(txak_clr),
    .arb_evt_i(arb), .tx_start_i(start), .tx_start_idx_i(start_idx),
    .tx_ok_i(ok), .tx_fail_i(fail),
    .pend_o(pend_o), .cancel_o(cancel_o), .abort_ack_o(abak_o), .tx_ack_o(txak_o),
    .tx_busy_o(busy_o), .tx_idx_o(idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    pend_set = '0; cancel_set = '0; abak_clr = '0; txak_clr = '0;
    arb = 1'b0; start = 1'b0; ok = 1'b0; fail = 1'b0; start_idx = '0;
  endtask

  // inputs already set at a negedge; hold one cycle, then release
  task automatic tick();
    @(negedge clk_i);
    clear_in();
  endtask

  task automatic do_op(input logic [2:0] op, input logic [4:0] idx);
    case (op)
      3'd0: pend_set[idx] = 1'b1;
      3'd1: cancel_set[idx] = 1'b1;
      3'd2: arb = 1'b1;
      3'd3: begin start = 1'b1; start_idx = idx; end
      3'd4: ok = 1'b1;
      3'd5: fail = 1'b1;
      3'd6: abak_clr[idx] = 1'b1;
      default: txak_clr[idx] = 1'b1;
    endcase
    tick();
  endtask

  task automatic do_reset();
    clear_in();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic string vec_req(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4/R5/R6";
      3'd3: return "R11";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    clear_in();
    repeat (2) @(negedge clk_i);
    chk("R1 pend", pend_o, '0);
    chk("R1 cancel", cancel_o, '0);
    chk("R1 acks", abak_o | txak_o, '0);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [4:0] ix;
      op = VEC[v][11:9];
      ix = VEC[v][8:4];
      do_op(op, ix);
      chk(vec_req(op), {28'd0, pend_o[ix], cancel_o[ix], abak_o[ix], txak_o[ix]},
          {28'd0, VEC[v][3:0]});
    end

    // R2 / R3: zero bits have no effect, mailbox 0 cancel ignored
    do_reset();
    pend_set = 32'h4; tick();
    chk("R2 set one", pend_o, 32'h4);
    tick();
    chk("R2 zero write", pend_o, 32'h4);
    cancel_set = 32'h1; tick();
    chk("R3 mbx0 cancel", cancel_o, 32'h0);

    // R6 / R11: arb in the same cycle as start does not abort the starting mailbox
    pend_set[10] = 1'b1; tick();
    cancel_set[10] = 1'b1; tick();
    start = 1'b1; start_idx = 5'd10; arb = 1'b1; tick();
    chk("R6 pend kept", {31'd0, pend_o[10]}, 32'd1);
    chk("R6 cancel kept", {31'd0, cancel_o[10]}, 32'd1);
    chk("R11 busy", {31'd0, busy_o}, 32'd1);
    chk("R11 idx", {27'd0, idx_o}, 32'd10);
    chk("R4 other cleared", pend_o, 32'h404);
    fail = 1'b1; tick();
    chk("R11 busy drops", {31'd0, busy_o}, 32'd0);
    chk("R8 abak 10", {31'd0, abak_o[10]}, 32'd1);

    // R9: hardware set beats host clear
    pend_set[3] = 1'b1; tick();
    start = 1'b1; start_idx = 5'd3; tick();
    ok = 1'b1; txak_clr[3] = 1'b1; tick();
    chk("R9 txak set wins", {31'd0, txak_o[3]}, 32'd1);
    txak_clr[3] = 1'b1; tick();
    chk("R9 txak cleared", {31'd0, txak_o[3]}, 32'd0);
    pend_set[6] = 1'b1; tick();
    start = 1'b1; start_idx = 5'd6; tick();
    fail = 1'b1; abak_clr[6] = 1'b1; tick();
    chk("R9 abak set wins", {31'd0, abak_o[6]}, 32'd1);

    // R10: new pending request survives completion clear
    pend_set[4] = 1'b1; tick();
    start = 1'b1; start_idx = 5'd4; tick();
    ok = 1'b1; pend_set[4] = 1'b1; tick();
    chk("R10 pend kept", {31'd0, pend_o[4]}, 32'd1);
    chk("R7 txak 4", {31'd0, txak_o[4]}, 32'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule